// File: doc/BRIEF.md
# Hold-Mode and Reset Sequencer

This block governs deep power-down and system reset for a small microcontroller core. The CPU raises a one-cycle strobe when it executes its power-down instruction; if the external power-down pin is low at that moment, the sequencer drops the clock-enable to the oscillator and core and stays there until the pin returns high. An external active-low reset pin is synchronised and qualified. It is honoured only while the power-down pin is high, so a board can keep the pin low to protect a sleeping system from stray reset pulses.

Any return to operation passes through a fixed oscillator-stabilisation wait of `WAIT_CYCLES` clocks (16384 by default). This applies after power-on, after a qualified reset, and when power-down is left. After a reset or power-on the core reset stays asserted through the whole wait. After power-down the core is held idle but not reset. The ready output rises only when the wait counter completes.

Top module: `hold_rst_seq`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1, `ready` is 0 and `clk_en` is 1. After `por_n` rises, `core_rst` stays 1 for exactly `WAIT_CYCLES` clock cycles, and then `ready` goes to 1.
- R2: A `hold_instr` strobe while running, with the synchronised `hold_pin` at 0, drops `clk_en` to 0 in the next cycle and keeps it there.
- R3: A `hold_instr` strobe while running, with `hold_pin` at 1, has no effect: `ready` stays 1 and `clk_en` stays 1.
- R4: When `hold_pin` returns to 1 during power-down, `clk_en` rises. Then `ready` stays 0 and `core_rst` stays 0 for exactly `WAIT_CYCLES` cycles before `ready` rises.
- R5: While the synchronised `hold_pin` is 0, a low level on `rst_pin_n` of any length never asserts `core_rst`.
- R6: With `hold_pin` at 1, a `rst_pin_n` low pulse is accepted only if it spans at least `RST_QUAL` (3) consecutive synchronised samples. Shorter pulses leave `ready` at 1.
- R7: An accepted reset pulse of L cycles keeps `core_rst` at 1 for exactly (L - RST_QUAL + 1) + `WAIT_CYCLES` consecutive cycles. After that, `ready` rises.
- R8: `ready` at 1 implies `clk_en` 1 and `core_rst` 0. `clk_en` at 0 implies `core_rst` 0 and `ready` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| hold_instr | input | 1 | One-cycle strobe from the CPU requesting power-down |
| hold_pin | input | 1 | External power-down pin level (asynchronous) |
| rst_pin_n | input | 1 | External reset pin, active low (asynchronous) |
| clk_en | output | 1 | Clock-enable to oscillator and core |
| core_rst | output | 1 | Reset to the core, active high |
| ready | output | 1 | Stabilisation wait done, core may execute |

## Verification
Two functions can collide: leaving power-down and accepting a reset. The bench provokes this by holding the reset pin low through a power-down, so the reset was ignored at first, and then raising the power-down pin while the reset pin is still low. The qualifier then begins counting in the same window in which the resume wait starts. The expected outcome is that the resume wait is abandoned: a core reset appears, then a full wait under reset follows, then `ready` rises. A sweep of reset pulse lengths 1 to 6 with exact expected reset durations pins down the qualification boundary.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
   typedef enum logic [2:0] {
      ST_WAIT   = 3'd0,  // stabilising under core reset
      ST_RUN    = 3'd1,  // core executing
      ST_HOLD   = 3'd2,  // clock stopped
      ST_RESUME = 3'd3,  // stabilising after power-down, no reset
      ST_RESET  = 3'd4   // qualified external reset held
   } hrs_state_t;
endpackage

// File: rtl/hrs_sync.sv
module hrs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hrs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[0] <= RST_VAL;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/hrs_rst_qual.sv
module hrs_rst_qual #(
   parameter int RST_QUAL = 3
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_s_n,
   input  logic hold_s,
   output logic rst_req
);
   localparam int QW = $clog2(RST_QUAL + 1);

   generate
      if (RST_QUAL < 1) begin : g_bad_qual
         $error("hrs_rst_qual: RST_QUAL must be at least 1");
      end
   endgenerate

   logic [QW-1:0] low_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         low_run <= '0;
      end else if (!rst_s_n && hold_s) begin
         if (low_run != QW'(RST_QUAL)) low_run <= low_run + 1'b1;
      end else begin
         low_run <= '0;
      end
   end

   assign rst_req = (low_run == QW'(RST_QUAL));

   AST_GATED_BY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      !hold_s |=> !rst_req); // R5
   AST_QUAL_MIN_LOW: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_req) |-> ($past(!rst_s_n) && $past(hold_s))); // R6
endmodule

// File: rtl/hrs_stab_cnt.sv
module hrs_stab_cnt #(
   parameter int WAIT_CYCLES = 16384
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   output logic done
);
   localparam int CW = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;

   generate
      if (WAIT_CYCLES < 2) begin : g_bad_wait
         $error("hrs_stab_cnt: WAIT_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign done = run && (cnt == CW'(WAIT_CYCLES - 1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             cnt <= '0;
      else if (!run || done)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
      32'(cnt) < WAIT_CYCLES); // R4
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      (!run && !$past(run)) |-> (cnt == '0)); // R4
endmodule

// File: rtl/hold_rst_seq.sv
module hold_rst_seq
   import hrs_pkg::*;
#(
   parameter int WAIT_CYCLES = 16384,
   parameter int RST_QUAL    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic hold_instr,
   input  logic hold_pin,
   input  logic rst_pin_n,
   output logic clk_en,
   output logic core_rst,
   output logic ready
);
   logic       hold_s;
   logic       rst_s_n;
   logic       rst_req;
   logic       wait_run;
   logic       wait_done;
   hrs_state_t state, state_nx;

   hrs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hold (
      .clk(clk), .por_n(por_n), .din(hold_pin), .dout(hold_s));

   hrs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
      .clk(clk), .por_n(por_n), .din(rst_pin_n), .dout(rst_s_n));

   hrs_rst_qual #(.RST_QUAL(RST_QUAL)) u_qual (
      .clk(clk), .por_n(por_n), .rst_s_n(rst_s_n), .hold_s(hold_s),
      .rst_req(rst_req));

   assign wait_run = (state == ST_WAIT) || (state == ST_RESUME);

   hrs_stab_cnt #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
      .clk(clk), .por_n(por_n), .run(wait_run), .done(wait_done));

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_WAIT, ST_RESUME: begin
            if (rst_req)        state_nx = ST_RESET;
            else if (wait_done) state_nx = ST_RUN;
         end
         ST_RUN: begin
            if (rst_req)                   state_nx = ST_RESET;
            else if (hold_instr && !hold_s) state_nx = ST_HOLD;
         end
         ST_HOLD: begin
            if (hold_s) state_nx = ST_RESUME;
         end
         ST_RESET: begin
            if (!rst_req) state_nx = ST_WAIT;
         end
         default: state_nx = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) state <= ST_WAIT;
      else        state <= state_nx;
   end

   assign clk_en   = (state != ST_HOLD);
   assign core_rst = (state == ST_WAIT) || (state == ST_RESET);
   assign ready    = (state == ST_RUN);

   AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      (ready && hold_instr && !hold_s && !rst_req) |=> !clk_en); // R2
   AST_HOLD_NOOP: assert property (@(posedge clk) disable iff (!por_n)
      (ready && hold_instr && hold_s && !rst_req) |=> ready); // R3
   AST_NO_RST_IN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      !clk_en |=> !core_rst); // R5
   AST_READY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ready) |-> $past(wait_done)); // R7
endmodule

// File: tb/tb_hold_rst_seq.sv
`timescale 1ns/1ps
module tb_hold_rst_seq;
   localparam int WAIT = 16384;
   localparam int QUAL = 3;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic hold_instr = 1'b0;
   logic hold_pin = 1'b1;
   logic rst_pin_n = 1'b1;
   logic clk_en, core_rst, ready;

   int n_chk = 0;
   int n_bad = 0;
   int viol  = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   hold_rst_seq #(.WAIT_CYCLES(WAIT), .RST_QUAL(QUAL), .SYNC_STAGES(2)) dut (
      .clk(clk), .por_n(por_n), .hold_instr(hold_instr), .hold_pin(hold_pin),
      .rst_pin_n(rst_pin_n), .clk_en(clk_en), .core_rst(core_rst), .ready(ready));

   // R8 consistency monitor
   always @(negedge clk) begin
      if (ready && (core_rst || !clk_en)) viol++;
      if (!clk_en && (core_rst || ready)) viol++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // low pulse of len cycles on rst_pin_n; returns whether core_rst seen and its run
   task automatic rst_pulse(input int len, output bit found, output int run);
      found = 1'b0;
      run = 0;
      for (int i = 0; i < len + WAIT + 60; i++) begin
         @(negedge clk);
         if (core_rst) begin
            found = 1'b1;
            run++;
         end else if (found) begin
            break;
         end else if (i > len + 20) begin
            break;
         end
         rst_pin_n = (i < len) ? 1'b0 : 1'b1;
      end
      rst_pin_n = 1'b1;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      for (int i = 0; i < WAIT + 80; i++) begin
         @(negedge clk);
         if (ready) break;
         n++;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int run;
      int tmp;
      int cnt_resume;
      int cnt_rst;
      bit found;

      // R1 reset state
      cycles(3);
      check(core_rst == 1'b1, "R1 core_rst in por", int'(core_rst), 1);
      check(ready == 1'b0, "R1 ready in por", int'(ready), 0);
      check(clk_en == 1'b1, "R1 clk_en in por", int'(clk_en), 1);

      // R1 wait length after power-on release
      @(posedge clk); #1 por_n = 1'b1;
      run = 0;
      for (int i = 0; i < WAIT + 50; i++) begin
         @(negedge clk);
         if (!core_rst) break;
         run++;
      end
      check(run == WAIT, "R1 por wait length", run, WAIT);
      check(ready == 1'b1, "R1 ready after wait", int'(ready), 1);

      // R3 power-down instruction with pin high is ignored
      hold_instr = 1'b1;
      @(negedge clk); hold_instr = 1'b0;
      cycles(4);
      check(ready == 1'b1 && clk_en == 1'b1, "R3 noop keeps running",
            int'(ready) + int'(clk_en), 2);

      // R5 reset ignored with hold pin low while running
      hold_pin = 1'b0;
      cycles(4);
      rst_pulse(6, found, run);
      check(!found, "R5 reset ignored pin low (run)", int'(found), 0);
      cycles(2);
      check(ready == 1'b1, "R5 still ready", int'(ready), 1);

      // R2 power-down entry
      hold_instr = 1'b1;
      @(negedge clk);
      hold_instr = 1'b0;
      check(clk_en == 1'b0, "R2 clk_en drops", int'(clk_en), 0);
      cycles(10);
      check(clk_en == 1'b0, "R2 clk_en stays low", int'(clk_en), 0);

      // R5 reset ignored during power-down
      rst_pulse(8, found, run);
      check(!found, "R5 reset ignored in hold", int'(found), 0);
      check(clk_en == 1'b0, "R5 still in hold", int'(clk_en), 0);

      // R4 resume length
      hold_pin = 1'b1;
      cnt_resume = 0;
      cnt_rst = 0;
      for (int i = 0; i < WAIT + 80; i++) begin
         @(negedge clk);
         if (ready) break;
         if (core_rst) cnt_rst++;
         if (clk_en && !core_rst) cnt_resume++;
      end
      check(cnt_resume == WAIT, "R4 resume wait length", cnt_resume, WAIT);
      check(cnt_rst == 0, "R4 no core reset on resume", cnt_rst, 0);
      check(ready == 1'b1, "R4 ready after resume", int'(ready), 1);

      // R6 / R7 sweep of reset pulse lengths
      for (int len = 1; len <= 6; len++) begin
         rst_pulse(len, found, run);
         check(found == (len >= QUAL), $sformatf("R6 accept len=%0d", len),
               int'(found), int'(len >= QUAL));
         if (len >= QUAL) begin
            tmp = (len - QUAL + 1) + WAIT;
            check(run == tmp, $sformatf("R7 reset length len=%0d", len), run, tmp);
         end
         cycles(2);
         check(ready == 1'b1, $sformatf("R7 ready after len=%0d", len), int'(ready), 1);
      end

      // collision: resume from power-down while reset pin held low
      hold_pin = 1'b0;
      cycles(4);
      hold_instr = 1'b1;
      @(negedge clk); hold_instr = 1'b0;
      rst_pin_n = 1'b0;
      cycles(6);
      check(clk_en == 1'b0 && core_rst == 1'b0, "R5 hold with reset low",
            int'(clk_en) + int'(core_rst), 0);
      hold_pin = 1'b1;
      found = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (core_rst) found = 1'b1;
      end
      check(found, "R6 reset accepted after resume", int'(found), 1);
      rst_pin_n = 1'b1;
      wait_ready(tmp);
      check(ready == 1'b1, "R7 ready after collision", int'(ready), 1);

      check(viol == 0, "R8 output consistency", viol, 0);

      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule